// File: doc/BRIEF.md
# Split Direct-Mapped Address Translation Unit

This block turns a virtual address into a physical address for a processor pipeline. It holds two direct-mapped translation buffers: one serves instruction fetches and the other serves loads and stores. A request carries a virtual address, an access kind and the privilege level. One cycle later the block returns:

- the physical address,
- the rights granted by the selected entry,
- a result code,
- an exception cause code.

On any fault it also keeps the virtual address that failed.

Software-style write strobes load the tag word or the frame word of one entry in either buffer. A reset clears every valid flag in both buffers. In supervisor mode, a low window of the address space skips the buffers altogether and maps one-to-one.

Top module: `tlb_xlate`

## Requirements
- R1: The virtual page number is `vaddr >> PAGE_BITS`, where `PAGE_BITS` defaults to 13. The entry consulted is the one selected by the low log2(entries) bits of that page number.
- R2: A lookup matches only when tag-word bits [31:PAGE_BITS] equal the full virtual page number. Any other case gives result 1 (no match), with rights 0 and physical address 0.
- R3: Bit 0 of the tag word is the valid flag. A matching entry whose flag is clear gives result 2 (invalid). A reset clears the valid flags of every entry but leaves the tag bits as they were.
- R4: For a fetch (access code 2), execute rights come from frame-word bit 5 in supervisor mode and from bit 4 in user mode. A fetch without execute rights gives result 3 (permission fault). Rights are reported as {exec, write, read}.
- R5: For a load (access code 0) or a store (access code 1), the rights come from frame-word bits. Supervisor read is bit 2 and supervisor write is bit 3. User read is bit 0 and user write is bit 1. A load without read rights, or a store without write rights, gives result 3.
- R6: On result 0 (hit), the physical address is frame-word bits [31:PAGE_BITS] joined with `vaddr[PAGE_BITS-1:0]`. On a permission fault the physical address is 0.
- R7: In supervisor mode, an address below `BYPASS_TOP` (default 0x2000) returns result 0. Its physical address equals the virtual address and its rights are {0,1,1}. This applies to every access kind.
- R8: Fetches consult only the instruction buffer; loads and stores consult only the data buffer. A write goes to the data buffer when `wr_dbuf` is 1. It loads the frame word when `wr_xlat` is 1 and the tag word otherwise.
- R9: Result 1 or 2 gives cause 1 (instruction miss) for a fetch and cause 2 (data miss) otherwise.
- R10: Result 3 gives cause 3 (instruction page fault) for a fetch and cause 4 (data page fault) otherwise. A hit gives cause 0.
- R11: On every response with a nonzero result, `fault_addr` captures that request's virtual address on the following edge. Otherwise `fault_addr` holds its value. Reset sets it to 0.
- R12: `rsp_vld` rises exactly one cycle after `req_vld`, with every response field valid in that cycle. An entry write is seen by a request strobed on the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| req_vaddr | input | ADDR_W | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_super | input | 1 | 1 = supervisor mode |
| wr_en | input | 1 | Entry write strobe |
| wr_dbuf | input | 1 | 1 = data buffer, 0 = instruction buffer |
| wr_xlat | input | 1 | 1 = frame word, 0 = tag word |
| wr_idx | input | WR_IDX_W | Entry index for the write |
| wr_data | input | ADDR_W | Word to write |
| rsp_vld | output | 1 | Response valid |
| rsp_paddr | output | ADDR_W | Physical address |
| rsp_rights | output | 3 | Granted rights {exec, write, read} |
| rsp_result | output | 2 | 0 hit, 1 no match, 2 invalid, 3 permission fault |
| rsp_cause | output | 3 | 0 none, 1 I-miss, 2 D-miss, 3 I-page, 4 D-page |
| fault_addr | output | ADDR_W | Last faulting virtual address |

## Verification
The bench builds the unit with 8 instruction entries and 16 data entries, keeping 13 offset bits and 32-bit addresses. The small instruction buffer makes index aliasing cheap to reach: two pages eight apart share one slot, so a stale tag gives a clean no-match. The unequal sizes also show whether each buffer takes its own index width from the address. Every entry is written before use, so each lookup has a known outcome. The bypass window is probed on both sides of its limit and in both privilege levels.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        RES_HIT     = 2'd0,
        RES_NOMATCH = 2'd1,
        RES_INVALID = 2'd2,
        RES_PERM    = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        EXC_NONE      = 3'd0,
        EXC_IMISS     = 3'd1,
        EXC_DMISS     = 3'd2,
        EXC_IPAGE     = 3'd3,
        EXC_DPAGE     = 3'd4
    } exc_e;

    // permission bit positions inside the frame word
    localparam int PB_UR = 0;
    localparam int PB_UW = 1;
    localparam int PB_SR = 2;
    localparam int PB_SW = 3;
    localparam int PB_UX = 4;
    localparam int PB_SX = 5;
    localparam int PERM_W = 6;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rights_t;

    function automatic rights_t grant(logic [PERM_W-1:0] pb, logic sup, logic fetch);
        rights_t g;
        g = '0;
        if (fetch) begin
            g.x = sup ? pb[PB_SX] : pb[PB_UX];
        end else begin
            g.r = sup ? pb[PB_SR] : pb[PB_UR];
            g.w = sup ? pb[PB_SW] : pb[PB_UW];
        end
        return g;
    endfunction

    function automatic exc_e cause_of(res_e r, logic fetch);
        exc_e c;
        case (r)
            RES_NOMATCH, RES_INVALID: c = fetch ? EXC_IMISS : EXC_DMISS;
            RES_PERM:                 c = fetch ? EXC_IPAGE : EXC_DPAGE;
            default:                  c = EXC_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tlb_array.sv
module tlb_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES   = 64,
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int TAG_W    = ADDR_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_tag,
    input  logic              we_frame,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_frame,
    output logic [PERM_W-1:0] rd_perm
);

    logic [TAG_W-1:0]  tag_q   [ENTRIES];
    logic [TAG_W-1:0]  frame_q [ENTRIES];
    logic [PERM_W-1:0] perm_q  [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (we_tag) begin
            tag_q[wr_idx] <= wr_data[ADDR_W-1:PAGE_BITS];
        end
        if (we_frame) begin
            frame_q[wr_idx] <= wr_data[ADDR_W-1:PAGE_BITS];
            perm_q[wr_idx]  <= wr_data[PERM_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (we_tag) begin
            valid_q[wr_idx] <= wr_data[0];
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_frame = frame_q[rd_idx];
    assign rd_perm  = perm_q[rd_idx];

    // R3: a tag write sets the entry's valid flag from bit 0 of the word
    assert_valid_load_R3: assert property (@(posedge clk) disable iff (rst)
        we_tag |=> (valid_q[$past(wr_idx)] == $past(wr_data[0])));

endmodule

// File: rtl/tlb_check.sv
module tlb_check
    import tlb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    localparam int TAG_W    = ADDR_W - PAGE_BITS
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  acc_e              acc,
    input  logic              sup,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_frame,
    input  logic [PERM_W-1:0] ent_perm,
    output res_e              result,
    output rights_t           rights,
    output logic [ADDR_W-1:0] paddr
);

    logic    fetch;
    logic    tag_eq;
    logic    allowed;
    rights_t granted;

    always_comb begin
        fetch   = (acc == ACC_FETCH);
        tag_eq  = (ent_tag == vaddr[ADDR_W-1:PAGE_BITS]);
        granted = grant(ent_perm, sup, fetch);
        if (fetch)                 allowed = granted.x;
        else if (acc == ACC_STORE) allowed = granted.w;
        else                       allowed = granted.r;

        if (!tag_eq)          result = RES_NOMATCH;
        else if (!ent_valid)  result = RES_INVALID;
        else if (!allowed)    result = RES_PERM;
        else                  result = RES_HIT;

        rights = (tag_eq && ent_valid) ? granted : '0;
        paddr  = (result == RES_HIT) ? {ent_frame, vaddr[PAGE_BITS-1:0]} : '0;
    end

    // R4/R5: a hit always carries the right the access needed
    always_comb begin
        if (result == RES_HIT) begin
            assert_hit_has_right_R4: assert (fetch ? rights.x :
                ((acc == ACC_STORE) ? rights.w : rights.r));
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ADDR_W                 = 32,
    parameter int PAGE_BITS              = 13,
    parameter int I_ENTRIES              = 64,
    parameter int D_ENTRIES              = 64,
    parameter logic [ADDR_W-1:0] BYPASS_TOP = 'h2000,
    localparam int I_IDX_W  = (I_ENTRIES > 1) ? $clog2(I_ENTRIES) : 1,
    localparam int D_IDX_W  = (D_ENTRIES > 1) ? $clog2(D_ENTRIES) : 1,
    localparam int WR_IDX_W = (I_IDX_W > D_IDX_W) ? I_IDX_W : D_IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_vld,
    input  logic [ADDR_W-1:0]   req_vaddr,
    input  logic [1:0]          req_acc,
    input  logic                req_super,
    input  logic                wr_en,
    input  logic                wr_dbuf,
    input  logic                wr_xlat,
    input  logic [WR_IDX_W-1:0] wr_idx,
    input  logic [ADDR_W-1:0]   wr_data,
    output logic                rsp_vld,
    output logic [ADDR_W-1:0]   rsp_paddr,
    output logic [2:0]          rsp_rights,
    output logic [1:0]          rsp_result,
    output logic [2:0]          rsp_cause,
    output logic [ADDR_W-1:0]   fault_addr
);

    localparam int TAG_W = ADDR_W - PAGE_BITS;

    // registered request
    logic              rq_vld;
    logic [ADDR_W-1:0] rq_vaddr;
    acc_e              rq_acc;
    logic              rq_super;

    always_ff @(posedge clk) begin
        if (rst) begin
            rq_vld   <= 1'b0;
            rq_vaddr <= '0;
            rq_acc   <= ACC_LOAD;
            rq_super <= 1'b0;
        end else begin
            rq_vld <= req_vld;
            if (req_vld) begin
                rq_vaddr <= req_vaddr;
                rq_acc   <= acc_e'(req_acc);
                rq_super <= req_super;
            end
        end
    end

    logic rq_fetch;
    assign rq_fetch = (rq_acc == ACC_FETCH);

    // buffers
    logic [TAG_W-1:0]  i_tag,   d_tag;
    logic              i_valid, d_valid;
    logic [TAG_W-1:0]  i_frame, d_frame;
    logic [PERM_W-1:0] i_perm,  d_perm;

    tlb_array #(.ENTRIES(I_ENTRIES), .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ibuf (
        .clk      (clk),
        .rst      (rst),
        .we_tag   (wr_en && !wr_dbuf && !wr_xlat),
        .we_frame (wr_en && !wr_dbuf &&  wr_xlat),
        .wr_idx   (wr_idx[I_IDX_W-1:0]),
        .wr_data  (wr_data),
        .rd_idx   (rq_vaddr[PAGE_BITS +: I_IDX_W]),
        .rd_tag   (i_tag),
        .rd_valid (i_valid),
        .rd_frame (i_frame),
        .rd_perm  (i_perm)
    );

    tlb_array #(.ENTRIES(D_ENTRIES), .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_dbuf (
        .clk      (clk),
        .rst      (rst),
        .we_tag   (wr_en && wr_dbuf && !wr_xlat),
        .we_frame (wr_en && wr_dbuf &&  wr_xlat),
        .wr_idx   (wr_idx[D_IDX_W-1:0]),
        .wr_data  (wr_data),
        .rd_idx   (rq_vaddr[PAGE_BITS +: D_IDX_W]),
        .rd_tag   (d_tag),
        .rd_valid (d_valid),
        .rd_frame (d_frame),
        .rd_perm  (d_perm)
    );

    // selected entry and permission check
    res_e              chk_result;
    rights_t           chk_rights;
    logic [ADDR_W-1:0] chk_paddr;

    tlb_check #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_check (
        .vaddr     (rq_vaddr),
        .acc       (rq_acc),
        .sup       (rq_super),
        .ent_tag   (rq_fetch ? i_tag   : d_tag),
        .ent_valid (rq_fetch ? i_valid : d_valid),
        .ent_frame (rq_fetch ? i_frame : d_frame),
        .ent_perm  (rq_fetch ? i_perm  : d_perm),
        .result    (chk_result),
        .rights    (chk_rights),
        .paddr     (chk_paddr)
    );

    // supervisor identity window and final response
    logic    bypass;
    res_e    fin_result;
    rights_t fin_rights;
    exc_e    fin_cause;

    always_comb begin
        bypass = rq_super && (rq_vaddr < BYPASS_TOP);
        if (bypass) begin
            fin_result = RES_HIT;
            fin_rights = '{x: 1'b0, w: 1'b1, r: 1'b1};
            rsp_paddr  = rq_vaddr;
        end else begin
            fin_result = chk_result;
            fin_rights = chk_rights;
            rsp_paddr  = chk_paddr;
        end
        fin_cause = rq_vld ? cause_of(fin_result, rq_fetch) : EXC_NONE;
    end

    assign rsp_vld    = rq_vld;
    assign rsp_result = fin_result;
    assign rsp_rights = fin_rights;
    assign rsp_cause  = fin_cause;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_addr <= '0;
        end else if (rq_vld && (fin_result != RES_HIT)) begin
            fault_addr <= rq_vaddr;
        end
    end

    // ---------------- assertions ----------------
    assert_resp_timing_R12: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> rsp_vld);

    assert_offset_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_result == RES_HIT) |->
        (rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));

    assert_bypass_ident_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && $past(req_super) && ($past(req_vaddr) < BYPASS_TOP)) |->
        (rsp_result == RES_HIT && rsp_paddr == $past(req_vaddr)));

    assert_miss_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && (rsp_result == RES_NOMATCH || rsp_result == RES_INVALID)) |->
        (rsp_cause == EXC_IMISS || rsp_cause == EXC_DMISS));

    assert_page_cause_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_result == RES_PERM) |->
        (rsp_cause == EXC_IPAGE || rsp_cause == EXC_DPAGE));

    assert_fault_latch_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_result != RES_HIT) |=> (fault_addr == $past(rq_vaddr)));

    assert_fault_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !(rsp_vld && rsp_result != RES_HIT) |=> $stable(fault_addr));

endmodule

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb;

    localparam int AW   = 32;
    localparam int PB   = 13;
    localparam int IENT = 8;
    localparam int DENT = 16;
    localparam int WIW  = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_vld;
    logic [AW-1:0] req_vaddr;
    logic [1:0]    req_acc;
    logic          req_super;
    logic          wr_en, wr_dbuf, wr_xlat;
    logic [WIW-1:0] wr_idx;
    logic [AW-1:0] wr_data;
    logic          rsp_vld;
    logic [AW-1:0] rsp_paddr;
    logic [2:0]    rsp_rights;
    logic [1:0]    rsp_result;
    logic [2:0]    rsp_cause;
    logic [AW-1:0] fault_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    tlb_xlate #(.ADDR_W(AW), .PAGE_BITS(PB), .I_ENTRIES(IENT), .D_ENTRIES(DENT)) u_dut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_super(req_super), .wr_en(wr_en), .wr_dbuf(wr_dbuf),
        .wr_xlat(wr_xlat), .wr_idx(wr_idx), .wr_data(wr_data), .rsp_vld(rsp_vld),
        .rsp_paddr(rsp_paddr), .rsp_rights(rsp_rights), .rsp_result(rsp_result),
        .rsp_cause(rsp_cause), .fault_addr(fault_addr)
    );

    // bench-side model of the two buffers
    logic [AW-1:0] mi_tag [IENT];
    logic [AW-1:0] mi_frm [IENT];
    logic          mi_v   [IENT];
    logic [AW-1:0] md_tag [DENT];
    logic [AW-1:0] md_frm [DENT];
    logic          md_v   [DENT];
    logic [AW-1:0] exp_fault = '0;

    localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2;

    task automatic check(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    task automatic write_word(logic dbuf, logic xl, int idx, logic [AW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_dbuf = dbuf; wr_xlat = xl; wr_idx = WIW'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (dbuf) begin
            if (xl) md_frm[idx] = d; else begin md_tag[idx] = d; md_v[idx] = d[0]; end
        end else begin
            if (xl) mi_frm[idx] = d; else begin mi_tag[idx] = d; mi_v[idx] = d[0]; end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < IENT; i++) mi_v[i] = 1'b0;
        for (int i = 0; i < DENT; i++) md_v[i] = 1'b0;
        exp_fault = '0;
    endtask

    // lookup one address and compare every response field with the model
    task automatic lookup(string tag, logic [AW-1:0] va, logic [1:0] acc, logic sup);
        logic [1:0]    e_res;
        logic [2:0]    e_rt;
        logic [AW-1:0] e_pa;
        logic [2:0]    e_cs;
        logic          fe;
        logic [AW-1:0] t, f;
        logic          v, need;
        fe = (acc == FE);
        e_rt = 3'b000; e_pa = '0;
        if (sup && va < 32'h2000) begin
            e_res = 2'd0; e_rt = 3'b011; e_pa = va;
        end else begin
            if (fe) begin
                t = mi_tag[va[PB +: 3]]; f = mi_frm[va[PB +: 3]]; v = mi_v[va[PB +: 3]];
            end else begin
                t = md_tag[va[PB +: 4]]; f = md_frm[va[PB +: 4]]; v = md_v[va[PB +: 4]];
            end
            if (t[AW-1:PB] != va[AW-1:PB]) e_res = 2'd1;
            else if (!v) e_res = 2'd2;
            else begin
                if (fe) e_rt = {sup ? f[5] : f[4], 2'b00};
                else    e_rt = {1'b0, sup ? f[3] : f[1], sup ? f[2] : f[0]};
                need = fe ? e_rt[2] : (acc == ST ? e_rt[1] : e_rt[0]);
                e_res = need ? 2'd0 : 2'd3;
                if (need) e_pa = {f[AW-1:PB], va[PB-1:0]};
            end
        end
        case (e_res)
            2'd0:       e_cs = 3'd0;
            2'd1, 2'd2: e_cs = fe ? 3'd1 : 3'd2;
            default:    e_cs = fe ? 3'd3 : 3'd4;
        endcase
        @(negedge clk);
        req_vld = 1'b1; req_vaddr = va; req_acc = acc; req_super = sup;
        @(negedge clk);
        req_vld = 1'b0;
        check(tag, "rsp_vld", AW'(rsp_vld), AW'(1'b1));
        check(tag, "result", AW'(rsp_result), AW'(e_res));
        check(tag, "rights", AW'(rsp_rights), AW'(e_rt));
        check(tag, "paddr", rsp_paddr, e_pa);
        check(tag, "cause", AW'(rsp_cause), AW'(e_cs));
        if (e_res != 2'd0) exp_fault = va;
        @(negedge clk);
        check("R11", "fault_addr", fault_addr, exp_fault);
    endtask

    function automatic logic [AW-1:0] tagw(logic [18:0] vpn, logic vld);
        return {vpn, 12'd0, vld};
    endfunction
    function automatic logic [AW-1:0] frmw(logic [18:0] pfn, logic [5:0] pb);
        return {pfn, 7'd0, pb};
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        check("R12", "rsp_vld after reset", AW'(rsp_vld), '0);
        check("R11", "fault_addr after reset", fault_addr, '0);
        check("R10", "cause idle", AW'(rsp_cause), '0);
    endtask

    task automatic t_fill_all();
        for (int i = 0; i < IENT; i++) begin
            write_word(1'b0, 1'b0, i, tagw(19'h7FFF0 + 19'(i), 1'b0));
            write_word(1'b0, 1'b1, i, frmw(19'h0, 6'h0));
        end
        for (int i = 0; i < DENT; i++) begin
            write_word(1'b1, 1'b0, i, tagw(19'h7FFF0 + 19'(i), 1'b0));
            write_word(1'b1, 1'b1, i, frmw(19'h0, 6'h0));
        end
    endtask

    task automatic t_user_data();
        // vpn 0x12345 -> data index 5; user read only
        write_word(1'b1, 1'b0, 5, tagw(19'h12345, 1'b1));
        write_word(1'b1, 1'b1, 5, frmw(19'h0ABCD, 6'b000001));
        lookup("R6", {19'h12345, 13'h1A7}, LD, 1'b0);
        lookup("R5", {19'h12345, 13'h004}, ST, 1'b0);
        lookup("R10", {19'h12345, 13'h1FF}, ST, 1'b0);
    endtask

    task automatic t_super_data();
        // supervisor write only, no supervisor read
        write_word(1'b1, 1'b1, 5, frmw(19'h0ABCD, 6'b001011));
        lookup("R5", {19'h12345, 13'h010}, ST, 1'b1);
        lookup("R5", {19'h12345, 13'h020}, LD, 1'b1);
        lookup("R5", {19'h12345, 13'h030}, ST, 1'b0);
    endtask

    task automatic t_fetch();
        // vpn 0x00403 -> instruction index 3; user execute only
        write_word(1'b0, 1'b0, 3, tagw(19'h00403, 1'b1));
        write_word(1'b0, 1'b1, 3, frmw(19'h1F00F, 6'b010000));
        lookup("R4", {19'h00403, 13'h0888}, FE, 1'b0);
        lookup("R4", {19'h00403, 13'h0100}, FE, 1'b1);
        write_word(1'b0, 1'b1, 3, frmw(19'h1F00F, 6'b100000));
        lookup("R4", {19'h00403, 13'h0104}, FE, 1'b1);
        lookup("R10", {19'h00403, 13'h0108}, FE, 1'b0);
    endtask

    task automatic t_alias();
        // vpn 0x0040B shares instruction index 3 with 0x00403
        lookup("R2", {19'h0040B, 13'h0000}, FE, 1'b0);
        lookup("R1", {19'h00413, 13'h0000}, FE, 1'b0);
        // data buffer is 16 deep: vpn 0x12355 shares index 5
        lookup("R9", {19'h12355, 13'h0040}, LD, 1'b0);
    endtask

    task automatic t_split();
        // address mapped only in data buffer, fetched: instruction buffer misses
        lookup("R8", {19'h12345, 13'h0040}, FE, 1'b0);
        // address mapped only in instruction buffer, loaded: data buffer misses
        lookup("R8", {19'h00403, 13'h0040}, LD, 1'b1);
    endtask

    task automatic t_invalid();
        write_word(1'b1, 1'b0, 9, tagw(19'h00009, 1'b0));
        write_word(1'b1, 1'b1, 9, frmw(19'h00777, 6'b001111));
        lookup("R3", {19'h00009, 13'h0ABC}, LD, 1'b0);
        write_word(1'b1, 1'b0, 9, tagw(19'h00009, 1'b1));
        lookup("R12", {19'h00009, 13'h0ABC}, LD, 1'b0);
    endtask

    task automatic t_bypass();
        lookup("R7", 32'h0000_1FFC, LD, 1'b1);
        lookup("R7", 32'h0000_0040, FE, 1'b1);
        lookup("R7", 32'h0000_1FFC, ST, 1'b0);
        lookup("R7", 32'h0000_2000, ST, 1'b1);
    endtask

    task automatic t_reset_clears();
        do_reset();
        check("R11", "fault_addr cleared", fault_addr, '0);
        lookup("R3", {19'h12345, 13'h0001}, LD, 1'b0);
        lookup("R3", {19'h00403, 13'h0001}, FE, 1'b0);
    endtask

    initial begin
        rst = 1'b1; req_vld = 1'b0; req_vaddr = '0; req_acc = '0; req_super = 1'b0;
        wr_en = 1'b0; wr_dbuf = 1'b0; wr_xlat = 1'b0; wr_idx = '0; wr_data = '0;
        for (int i = 0; i < IENT; i++) begin mi_tag[i] = '0; mi_frm[i] = '0; mi_v[i] = 1'b0; end
        for (int i = 0; i < DENT; i++) begin md_tag[i] = '0; md_frm[i] = '0; md_v[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_fill_all();
        t_user_data();
        t_super_data();
        t_fetch();
        t_alias();
        t_split();
        t_invalid();
        t_bypass();
        t_reset_clears();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R12 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule